// File: doc/BRIEF.md
# Single-Segment Card Data DMA Engine

This engine moves one block-data transfer between a card data stream and system memory, using a single contiguous buffer. Software programs a transfer through a small register window. It sets the direction, the beat width, and whether the memory address advances or stays fixed. It also writes the 8-byte-aligned buffer address and sets a self-clearing start bit. The card data path supplies the block size and the block count, and the transfer length in bytes is their product.

Toward memory, the engine issues one beat at a time over a request/ready handshake. Toward the card, it exchanges beats with the data FIFO over valid/ready streams. A memory-to-card beat is first fetched from memory and then pushed into the transmit stream. A card-to-memory beat is first pulled from the receive stream and then stored to memory. A done flag, mirrored on the interrupt output, is raised when the last beat is accepted.

Two active-low channel release bits can hold either direction in reset. Clearing the bit for the running direction aborts the transfer at once.

Top module: `sddma_top`

## Requirements
- R1: Register offsets are: mode 0x410, control 0x414, channel release 0x418, status 0x41C, buffer address low 0x440, buffer address high 0x444. Mode, address and channel release registers read back as written. Mode readback keeps bits [17:16], [5:4] and 0. Release readback keeps bits [9:8]. Control always reads 0. After reset the release register reads 0x300 and every other register reads 0.
- R2: Writing 1 to control bit 0 starts a transfer. The start is accepted only when the engine is idle and the channel for the programmed direction is released. Status bit 0 (busy) reads 1 from the next cycle until the transfer ends.
- R3: A start written while busy is ignored. The running transfer keeps its latched address, length and mode, even if the address registers are rewritten.
- R4: An accepted start with buffer address bits [2:0] not all zero does not run. It sets status bit 2 (alignment error), leaves busy at 0 and issues no memory request.
- R5: Mode bits [17:16] equal to 1 select card-to-memory. Any other value selects memory-to-card. In memory-to-card mode each beat is read from memory (mem_we=0), and the read data then appears on tx_data with tx_valid set.
- R6: In card-to-memory mode each beat is taken from rx_data when rx_valid and rx_ready are both high. It is then written to memory with mem_we=1 and that data on mem_wdata.
- R7: Mode bits [5:4] give the beat width as 8, 16, 32 or 64 bits (codes 0 to 3). Data occupies the low lanes and the unused upper lanes read 0. The number of beats is floor(blk_size*blk_count / beat bytes).
- R8: With mode bit 0 set, the memory address of beat k is the base plus k times the beat bytes. With it clear, every beat uses the base address.
- R9: Status bit 1 (done) and irq rise in the cycle after the last beat is accepted. Both are cleared by the next accepted start, or while the release bit of the finished direction is low.
- R10: Release bit 8 serves memory-to-card and bit 9 serves card-to-memory. A 0 holds that channel in reset. Clearing the bit of a running transfer aborts it: busy drops, no further handshakes occur, and done stays 0.
- R11: An accepted, aligned start whose length gives zero beats sets done in the next cycle and makes no memory request.
- R12: Once mem_req is raised, it and mem_addr stay unchanged until mem_ready is seen, unless the transfer is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| blk_size | input | 16 | Block size in bytes, from the data path |
| blk_count | input | 16 | Number of blocks, from the data path |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 64 | Memory byte address of the beat |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the beat |
| tx_valid | output | 1 | Beat to card FIFO valid |
| tx_data | output | 64 | Beat to card FIFO |
| tx_ready | input | 1 | Card FIFO accepts the beat |
| rx_valid | input | 1 | Beat from card FIFO valid |
| rx_data | input | 64 | Beat from card FIFO |
| rx_ready | output | 1 | Engine accepts a beat from the card FIFO |
| irq | output | 1 | Done interrupt (level) |

## Verification
Several properties are checked on every cycle:
- the memory request stays stable until it is accepted;
- a transmit beat follows a completed memory read, and a memory write follows a completed receive;
- the beat counter never underflows, and the address holds while fixed;
- done and error flags never coexist with busy;
- a cleared release bit ends a running transfer within one cycle.

Some behaviours can only be shown by the bench scenarios. These are the actual data values and address sequence per beat width, the beat counts, and the ignored mid-transfer start. They also include the alignment rejection, the zero-length completion, and the ways done is cleared.

// File: rtl/sddma_pkg.sv
package sddma_pkg;

   localparam logic [11:0] OFS_MODE    = 12'h410;
   localparam logic [11:0] OFS_CTRL    = 12'h414;
   localparam logic [11:0] OFS_REL     = 12'h418;
   localparam logic [11:0] OFS_STAT    = 12'h41C;
   localparam logic [11:0] OFS_ADDR_LO = 12'h440;
   localparam logic [11:0] OFS_ADDR_HI = 12'h444;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_PUSH  = 3'd2,
      ST_PULL  = 3'd3,
      ST_STORE = 3'd4
   } seq_st_e;

   typedef struct packed {
      logic       to_mem;
      logic [1:0] wcode;
      logic       incr;
   } xfer_cfg_t;

   function automatic logic [63:0] lane_mask(input logic [1:0] w);
      case (w)
         2'd0:    lane_mask = 64'h0000_0000_0000_00FF;
         2'd1:    lane_mask = 64'h0000_0000_0000_FFFF;
         2'd2:    lane_mask = 64'h0000_0000_FFFF_FFFF;
         default: lane_mask = 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/sddma_regs.sv
module sddma_regs
   import sddma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int REG_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic              err_i,
   output xfer_cfg_t         cfg_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [1:0]        rel_o,
   output logic              start_o
);

   logic [1:0]  dir_q;
   logic [1:0]  wcode_q;
   logic        incr_q;
   logic [31:0] lo_q;
   logic [1:0]  rel_q;
   logic [31:0] hi_rd;

   logic wr_mode, wr_ctrl, wr_rel, wr_lo, wr_hi;
   assign wr_mode = reg_we && (reg_addr == REG_AW'(OFS_MODE));
   assign wr_ctrl = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
   assign wr_rel  = reg_we && (reg_addr == REG_AW'(OFS_REL));
   assign wr_lo   = reg_we && (reg_addr == REG_AW'(OFS_ADDR_LO));
   assign wr_hi   = reg_we && (reg_addr == REG_AW'(OFS_ADDR_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         wcode_q <= '0;
         incr_q  <= 1'b0;
         lo_q    <= '0;
         rel_q   <= 2'b11;
      end else begin
         if (wr_mode) begin
            dir_q   <= reg_wdata[17:16];
            wcode_q <= reg_wdata[5:4];
            incr_q  <= reg_wdata[0];
         end
         if (wr_lo)  lo_q  <= reg_wdata;
         if (wr_rel) rel_q <= reg_wdata[9:8];
      end
   end

   generate
      if (ADDR_W > 32) begin : g_hi
         logic [ADDR_W-33:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_hi) hi_q <= reg_wdata[ADDR_W-33:0];
         end
         assign base_o = {hi_q, lo_q};
         assign hi_rd  = 32'(hi_q);
      end else begin : g_no_hi
         assign base_o = lo_q;
         assign hi_rd  = '0;
      end
   endgenerate

   // The release bits take effect in the same cycle they are written.
   assign rel_o   = wr_rel ? reg_wdata[9:8] : rel_q;
   assign start_o = wr_ctrl && reg_wdata[0];

   assign cfg_o.to_mem = (dir_q == 2'd1);
   assign cfg_o.wcode  = wcode_q;
   assign cfg_o.incr   = incr_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFS_MODE))
         reg_rdata = {14'b0, dir_q, 10'b0, wcode_q, 3'b0, incr_q};
      else if (reg_addr == REG_AW'(OFS_REL))
         reg_rdata = {22'b0, rel_q, 8'b0};
      else if (reg_addr == REG_AW'(OFS_STAT))
         reg_rdata = {29'b0, err_i, done_i, busy_i};
      else if (reg_addr == REG_AW'(OFS_ADDR_LO))
         reg_rdata = lo_q;
      else if (reg_addr == REG_AW'(OFS_ADDR_HI))
         reg_rdata = hi_rd;
   end

   wire unused_wdata = ^{reg_wdata[31:18], reg_wdata[15:10], reg_wdata[7:6],
                         reg_wdata[3:1]};

endmodule

// File: rtl/sddma_addr_gen.sv
module sddma_addr_gen
   import sddma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  beats_i,
   input  xfer_cfg_t         cfg_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic [ADDR_W-1:0] stride_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         rem_q    <= '0;
         stride_q <= '0;
      end else if (load_i) begin
         addr_q   <= base_i;
         rem_q    <= beats_i;
         stride_q <= cfg_i.incr ? (ADDR_W'(1) << cfg_i.wcode) : '0;
      end else if (step_i) begin
         addr_q <= addr_q + stride_q;
         rem_q  <= rem_q - CNT_W'(1);
      end
   end

   assign addr_o = addr_q;
   assign last_o = (rem_q == CNT_W'(1));

   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (rem_q != '0))
      else $error("beat counter stepped at zero");

   p_fixed_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && (stride_q == '0)) |=> $stable(addr_q))
      else $error("fixed address moved");

endmodule

// File: rtl/sddma_seq.sv
module sddma_seq
   import sddma_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        rel_i,
   input  xfer_cfg_t         cfg_i,
   input  logic              aligned_i,
   input  logic              zero_i,
   input  logic              last_i,
   output logic              load_o,
   output logic              step_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [1:0]        mem_size_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   output logic              tx_valid_o,
   output logic [DATA_W-1:0] tx_data_o,
   input  logic              tx_ready_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_data_i,
   output logic              rx_ready_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              run_rel_o
);

   seq_st_e           st_q;
   xfer_cfg_t         act_q;
   logic [DATA_W-1:0] beat_q;
   logic              done_q, err_q;
   logic              accept;

   assign accept    = start_i && (st_q == ST_IDLE) && rel_i[cfg_i.to_mem];
   assign run_rel_o = rel_i[act_q.to_mem];
   assign load_o    = accept && aligned_i && !zero_i;
   assign step_o    = ((st_q == ST_PUSH) && tx_ready_i) ||
                      ((st_q == ST_STORE) && mem_ready_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         act_q  <= '0;
         beat_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (!run_rel_o) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         if (accept) begin
            act_q  <= cfg_i;
            done_q <= aligned_i && zero_i;
            err_q  <= !aligned_i;
            if (aligned_i && !zero_i)
               st_q <= cfg_i.to_mem ? ST_PULL : ST_FETCH;
         end else if ((st_q != ST_IDLE) && !run_rel_o) begin
            st_q <= ST_IDLE;
         end else begin
            case (st_q)
               ST_FETCH: if (mem_ready_i) begin
                  beat_q <= mem_rdata_i & lane_mask(act_q.wcode);
                  st_q   <= ST_PUSH;
               end
               ST_PULL: if (rx_valid_i) begin
                  beat_q <= rx_data_i & lane_mask(act_q.wcode);
                  st_q   <= ST_STORE;
               end
               ST_PUSH, ST_STORE: if (step_o) begin
                  if (last_i) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     st_q <= (st_q == ST_PUSH) ? ST_FETCH : ST_PULL;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign mem_req_o   = (st_q == ST_FETCH) || (st_q == ST_STORE);
   assign mem_we_o    = (st_q == ST_STORE);
   assign mem_size_o  = act_q.wcode;
   assign mem_wdata_o = beat_q;
   assign tx_valid_o  = (st_q == ST_PUSH);
   assign tx_data_o   = beat_q;
   assign rx_ready_o  = (st_q == ST_PULL);

   p_push_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> $past(mem_req_o && mem_ready_i && !mem_we_o))
      else $error("transmit beat without a memory read");

   p_store_after_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_o) |-> $past(rx_ready_o && rx_valid_i))
      else $error("memory write without a received beat");

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o)
      else $error("done while busy");

   p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !mem_req_o))
      else $error("alignment error with activity");

   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !run_rel_o && !accept) |=> (!busy_o && !done_o))
      else $error("transfer survived channel reset");

endmodule

// File: rtl/sddma_top.sv
module sddma_top
   import sddma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int REG_AW = 12,
   parameter int BSZ_W  = 16,
   parameter int BCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [BSZ_W-1:0]  blk_size,
   input  logic [BCNT_W-1:0] blk_count,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              irq
);

   localparam int CNT_W   = BSZ_W + BCNT_W;
   localparam int ALIGN_B = 3;

   initial begin
      assert (DATA_W == 64) else $error("DATA_W must be 64");
      assert (ADDR_W >= 32 && ADDR_W <= 64) else $error("ADDR_W out of range");
      assert (REG_AW >= 12) else $error("REG_AW too small");
   end

   xfer_cfg_t         cfg;
   logic [ADDR_W-1:0] base;
   logic [1:0]        rel;
   logic              start, load, step, last;
   logic              busy, done, err, run_rel;
   logic [CNT_W-1:0]  len, beats;

   assign len   = CNT_W'(blk_size) * CNT_W'(blk_count);
   assign beats = len >> cfg.wcode;

   sddma_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy_i(busy), .done_i(done), .err_i(err),
      .cfg_o(cfg), .base_o(base), .rel_o(rel), .start_o(start)
   );

   sddma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(load), .base_i(base),
      .beats_i(beats), .cfg_i(cfg), .step_i(step),
      .addr_o(mem_addr), .last_o(last)
   );

   sddma_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rel_i(rel), .cfg_i(cfg),
      .aligned_i(base[ALIGN_B-1:0] == '0), .zero_i(beats == '0),
      .last_i(last), .load_o(load), .step_o(step),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
      .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
      .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
      .busy_o(busy), .done_o(done), .err_o(err), .run_rel_o(run_rel)
   );

   assign irq = done;

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready && run_rel) |=> (mem_req && $stable(mem_addr)))
      else $error("memory request dropped or moved before ready");

   p_req_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[ALIGN_B-1:0] == '0 || mem_size != 2'd3))
      else $error("64-bit beat at unaligned address");

endmodule

// File: tb/tb_sddma_top.sv
module tb_sddma_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] blk_size = '0, blk_count = '0;
   logic        mem_req, mem_we, mem_ready = 1'b0;
   logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [1:0]  mem_size;
   logic        tx_valid, tx_ready = 1'b0;
   logic [63:0] tx_data;
   logic        rx_valid = 1'b0, rx_ready;
   logic [63:0] rx_data = '0;
   logic        irq;

   always #4 clk = ~clk;   // 125 MHz

   sddma_top dut (.*);

   int n_chk = 0, n_bad = 0, cyc = 0;
   int nr = 0, nw = 0, ntx = 0, nrx = 0;
   logic [63:0] e_base = '0;
   logic [1:0]  e_w = '0;
   logic        e_inc = 1'b0, slow = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] memfun(input logic [63:0] a);
      return {a[31:0] ^ 32'h5A5A_C3C3, a[31:0] * 32'h0009_E377 + 32'h1234_5678};
   endfunction
   function automatic logic [63:0] srcfun(input int k);
      return {32'(k) * 32'h0101_0305 + 32'hBEEF, ~(32'(k) * 32'h0070_0019)};
   endfunction
   function automatic logic [63:0] wmask(input logic [1:0] w);
      return (w == 2'd3) ? '1 : ((64'd1 << (8 << w)) - 64'd1);
   endfunction
   function automatic logic [63:0] expaddr(input int k);
      return e_inc ? e_base + (64'(k) << e_w) : e_base;
   endfunction

   // memory, transmit sink and receive source models
   always @(negedge clk) begin
      int lim;
      lim = slow ? 1 : 5;
      mem_ready = mem_req && ($urandom_range(0, 9) < lim);
      mem_rdata = memfun(mem_addr);
      tx_ready  = ($urandom_range(0, 9) < lim);
      rx_valid  = ($urandom_range(0, 9) < lim);
      rx_data   = srcfun(nrx);
      if (rst_n && mem_req && mem_ready) begin
         if (mem_we) begin
            chk(mem_addr == expaddr(nw), "R8 write address", mem_addr, expaddr(nw));
            chk(mem_wdata == (srcfun(nw) & wmask(e_w)), "R6/R7 write data",
                mem_wdata, srcfun(nw) & wmask(e_w));
            nw++;
         end else begin
            chk(mem_addr == expaddr(nr), "R5/R8 read address", mem_addr, expaddr(nr));
            nr++;
         end
      end
      if (rst_n && tx_valid && tx_ready) begin
         chk(tx_data == (memfun(expaddr(ntx)) & wmask(e_w)), "R5/R7 tx data",
             tx_data, memfun(expaddr(ntx)) & wmask(e_w));
         ntx++;
      end
      if (rst_n && rx_valid && rx_ready) nrx++;
   end

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic begin_xfer(input bit dir, input logic [1:0] w, input bit inc,
                             input logic [63:0] base, input logic [15:0] bsz, input logic [15:0] bcnt);
      @(negedge clk);
      e_base = base; e_w = w; e_inc = inc;
      nr = 0; nw = 0; ntx = 0; nrx = 0;
      blk_size = bsz; blk_count = bcnt;
      reg_wr(12'h410, (32'(dir) << 16) | (32'(w) << 4) | 32'(inc));
      reg_wr(12'h440, base[31:0]);
      reg_wr(12'h444, base[63:32]);
      reg_wr(12'h414, 32'h1);
   endtask

   task automatic finish_xfer(input bit dir, input string tag);
      logic [31:0] s;
      int beats;
      beats = (int'(blk_size) * int'(blk_count)) >> e_w;
      for (int i = 0; i < 20000 && !irq; i++) @(negedge clk);
      chk(irq, {tag, " R9 irq after last beat"}, 64'(irq), 64'd1);
      repeat (2) @(negedge clk);
      if (dir) begin
         chk(nw == beats, {tag, " R6/R7 beat count"}, 64'(nw), 64'(beats));
         chk(nr == 0, {tag, " R6 no memory reads"}, 64'(nr), 64'd0);
      end else begin
         chk(ntx == beats && nr == beats, {tag, " R5/R7 beat count"}, 64'(ntx), 64'(beats));
         chk(nw == 0, {tag, " R5 no memory writes"}, 64'(nw), 64'd0);
      end
      reg_rd(12'h41C, s);
      chk(s == 32'h2, {tag, " R9 status done"}, 64'(s), 64'h2);
   endtask

   initial begin
      logic [31:0] s;
      int saved;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      reg_rd(12'h418, s); chk(s == 32'h300, "R1 release reset value", 64'(s), 64'h300);
      reg_rd(12'h41C, s); chk(s == 32'h0, "R1 status reset value", 64'(s), 64'h0);
      reg_rd(12'h410, s); chk(s == 32'h0, "R1 mode reset value", 64'(s), 64'h0);
      chk(!mem_req && !tx_valid && !rx_ready && !irq, "R2 idle outputs", 64'(mem_req), 64'h0);

      // register readback
      reg_wr(12'h410, 32'hFFFF_FFFF); reg_rd(12'h410, s);
      chk(s == 32'h0003_0031, "R1 mode readback", 64'(s), 64'h30031);
      reg_wr(12'h440, 32'hCAFE_0008); reg_rd(12'h440, s);
      chk(s == 32'hCAFE_0008, "R1 address low readback", 64'(s), 64'hCAFE0008);
      reg_wr(12'h444, 32'h0000_1234); reg_rd(12'h444, s);
      chk(s == 32'h1234, "R1 address high readback", 64'(s), 64'h1234);
      reg_rd(12'h414, s); chk(s == 32'h0, "R1 control reads zero", 64'(s), 64'h0);

      // directed transfers
      begin_xfer(1'b0, 2'd3, 1'b1, 64'h0000_0001_0000_1000, 16'd32, 16'd2);
      finish_xfer(1'b0, "R5 mem-to-card 64b");
      begin_xfer(1'b1, 2'd2, 1'b1, 64'h0000_2000, 16'd16, 16'd3);
      finish_xfer(1'b1, "R6 card-to-mem 32b");
      begin_xfer(1'b0, 2'd0, 1'b0, 64'h0000_3000, 16'd5, 16'd1);
      finish_xfer(1'b0, "R8 fixed address 8b");
      begin_xfer(1'b1, 2'd1, 1'b0, 64'h0000_3008, 16'd7, 16'd1);
      finish_xfer(1'b1, "R7 16b truncated length");

      // R11 zero length
      begin_xfer(1'b0, 2'd3, 1'b1, 64'h0000_4000, 16'd0, 16'd4);
      finish_xfer(1'b0, "R11 zero length");

      // R4 misaligned start also clears done (R9)
      begin_xfer(1'b0, 2'd3, 1'b1, 64'h0000_5003, 16'd64, 16'd1);
      repeat (10) @(negedge clk);
      reg_rd(12'h41C, s);
      chk(s == 32'h4, "R4 R9 misaligned: error set, done cleared", 64'(s), 64'h4);
      chk(nr == 0 && !mem_req, "R4 no memory request", 64'(nr), 64'h0);

      // R9 done cleared by channel reset
      begin_xfer(1'b0, 2'd2, 1'b1, 64'h0000_6000, 16'd8, 16'd1);
      finish_xfer(1'b0, "R9 pre-clear run");
      reg_wr(12'h418, 32'h200);
      reg_rd(12'h41C, s);
      chk(s == 32'h0 && !irq, "R9 done cleared by channel reset", 64'(s), 64'h0);
      reg_wr(12'h418, 32'h300);

      // R3 start while busy ignored
      slow = 1'b1;
      begin_xfer(1'b0, 2'd3, 1'b1, 64'h0000_7000, 16'd64, 16'd1);
      repeat (6) @(negedge clk);
      reg_wr(12'h440, 32'h0000_9000);
      reg_wr(12'h414, 32'h1);
      finish_xfer(1'b0, "R3 restart ignored");

      // R10 abort of a running card-to-memory transfer
      begin_xfer(1'b1, 2'd3, 1'b1, 64'h0000_A000, 16'd128, 16'd1);
      repeat (8) @(negedge clk);
      reg_wr(12'h418, 32'h100);
      reg_rd(12'h41C, s);
      chk(s == 32'h0, "R10 abort clears busy", 64'(s), 64'h0);
      saved = nw;
      repeat (20) @(negedge clk);
      chk(nw == saved && !mem_req && !rx_ready && !irq, "R10 no handshakes after abort",
          64'(nw), 64'(saved));
      reg_rd(12'h418, s); chk(s == 32'h100, "R1 R10 release readback", 64'(s), 64'h100);
      reg_wr(12'h418, 32'h300);
      slow = 1'b0;

      // R10 start on a held channel is ignored (R2)
      reg_wr(12'h418, 32'h200);
      begin_xfer(1'b0, 2'd3, 1'b1, 64'h0000_B000, 16'd16, 16'd1);
      repeat (5) @(negedge clk);
      reg_rd(12'h41C, s);
      chk(s == 32'h0 && nr == 0, "R2 R10 held channel start ignored", 64'(s), 64'h0);
      reg_wr(12'h418, 32'h300);

      // constrained random transfers
      for (int i = 0; i < 24; i++) begin
         bit dir, inc;
         logic [1:0] w;
         logic [63:0] b;
         dir = 1'($urandom_range(0, 1));
         inc = ($urandom_range(0, 3) != 0);
         w   = 2'($urandom_range(0, 3));
         b   = {32'($urandom_range(0, 15)), $urandom & 32'hFFFF_FFF8};
         begin_xfer(dir, w, inc, b, 16'($urandom_range(1, 64)), 16'($urandom_range(1, 4)));
         finish_xfer(dir, "R5/R6/R7/R8 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule